// File: doc/BRIEF.md
# Dependent Micro-op Pair Fuser

The block takes a buffered group of decoded micro-ops and picks out producer/consumer pairs that a later pipeline stage can treat as one fused macro-op. Each entry carries a destination register with a valid bit, two source registers with valid bits, a single-cycle flag and a memory flag. Entries are loaded one per cycle through a write port. A start pulse then sets the number of live entries, and the block scans them.

The scan makes two ordered forward sweeps over entries 1 to len-1 and judges one tail candidate per cycle. The first sweep admits only single-cycle tails. The second sweep also admits multi-cycle tails, such as loads and stores. For each tail, the head is the most recent earlier writer of one of the tail's sources. The pair is accepted only if the operand-count test and the memory-ordering test both pass. When the scan ends, a read port returns, for any entry, whether it is fused, whether it is a tail, and the index of its head.

Dependences are found by comparing register numbers only. The block does not rename registers or move code.

Top module: `fuse_pair_scan`

## Requirements
- R1: Entry writes (wr_en_i) and start pulses are accepted while busy_o is low. Both are ignored while busy_o is high. A scan therefore runs entirely on the table as it stood at its start.
- R2: A start pulse with len_i >= 2 raises busy_o after that edge. busy_o then stays high for exactly 2*(len_i-1) further edges, after which done_o is high. With len_i of 0 or 1, done_o is high right after the start edge. done_o stays high until the next start.
- R3: In the first sweep, only entries whose single-cycle flag is 1 are tail candidates. In both sweeps, a head must have its single-cycle flag set to 1.
- R4: The second sweep also admits tails whose single-cycle flag is 0. It runs only after the first sweep has finished, so pairs found in the first sweep take precedence.
- R5: The head candidate is the highest-indexed entry below the tail whose destination is valid and equal to a valid tail source. No older writer is considered as a fallback.
- R6: An entry already fused, as head or as tail, is skipped as a tail candidate. If the head candidate is already fused, no pair is formed for that tail.
- R7: A pair is rejected if more than two distinct registers are read. The count takes the head's valid sources together with the tail's valid sources, leaving out any tail source that equals the head's destination.
- R8: If the head or the tail has its memory flag set to 1, the pair is rejected when any entry strictly between them has its memory flag set to 1.
- R9: For the entry at rd_idx_i, the read port gives: rd_fused_o = 1 if the entry is in a pair, rd_tail_o = 1 if it is a tail, and rd_head_o = the head's index (0 when it is not a tail). Reset and each accepted start clear all of this.
- R10: Entries at index len_i or above are never tails, and they are never heads of any pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write one table entry |
| wr_idx_i | input | 5 | Entry index to write |
| wr_dst_i | input | 5 | Destination register |
| wr_dst_v_i | input | 1 | Destination valid |
| wr_src0_i | input | 5 | First source register |
| wr_src0_v_i | input | 1 | First source valid |
| wr_src1_i | input | 5 | Second source register |
| wr_src1_v_i | input | 1 | Second source valid |
| wr_single_i | input | 1 | 1 = single-cycle micro-op |
| wr_mem_i | input | 1 | 1 = memory micro-op |
| start_i | input | 1 | Begin a scan |
| len_i | input | 6 | Number of live entries (0 to 32) |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | Scan finished, results valid |
| rd_idx_i | input | 5 | Entry to read back |
| rd_fused_o | output | 1 | Entry belongs to a pair |
| rd_tail_o | output | 1 | Entry is the tail of a pair |
| rd_head_o | output | 5 | Head index of that tail |

## Verification
The done flag is due exactly 2*(len-1) edges after the start edge, or on the start edge itself for len below 2. The bench counts edges from the start edge and compares that count against the formula.

The read port is combinational. The driver sets an index just after a rising edge and queues the expected fields, which come from an independent two-sweep model. The monitor pops the queue and compares on the following falling edge, so every readback is sampled half a cycle after it is driven.

Disturbance writes and a stray start are injected in the middle of a scan. Their lack of effect is seen both in the done latency and in the pair map read back afterwards.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  parameter int unsigned REG_W = 5;

  typedef struct packed {
    logic [REG_W-1:0] dst;
    logic             dst_v;
    logic [REG_W-1:0] src0;
    logic             src0_v;
    logic [REG_W-1:0] src1;
    logic             src1_v;
    logic             single;
    logic             mem;
  } uop_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_SCAN = 2'd1,
    S_DONE = 2'd2
  } scan_st_e;
endpackage

// File: rtl/fuse_writer_find.sv
module fuse_writer_find
  import fuse_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 32,
  localparam int unsigned IDX_W = $clog2(N_ENTRIES)
) (
  input  logic [N_ENTRIES-1:0]            dst_v_i,
  input  logic [N_ENTRIES-1:0][REG_W-1:0] dst_i,
  input  logic [REG_W-1:0]                src_i,
  input  logic                            src_v_i,
  input  logic [IDX_W-1:0]                limit_i,
  output logic                            found_o,
  output logic [IDX_W-1:0]                idx_o
);
  // later matches overwrite earlier ones: nearest writer wins
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int j = 0; j < int'(N_ENTRIES); j++) begin
      if (src_v_i && dst_v_i[j] && (dst_i[j] == src_i) && (IDX_W'(j) < limit_i)) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(j);
      end
    end
  end
endmodule

// File: rtl/fuse_pair_check.sv
module fuse_pair_check
  import fuse_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 32,
  parameter int unsigned MAX_SRCS  = 2,
  localparam int unsigned IDX_W = $clog2(N_ENTRIES)
) (
  input  logic [REG_W-1:0]     head_dst_i,
  input  logic [REG_W-1:0]     head_src0_i,
  input  logic                 head_src0_v_i,
  input  logic [REG_W-1:0]     head_src1_i,
  input  logic                 head_src1_v_i,
  input  logic                 head_mem_i,
  input  logic [REG_W-1:0]     tail_src0_i,
  input  logic                 tail_src0_v_i,
  input  logic [REG_W-1:0]     tail_src1_i,
  input  logic                 tail_src1_v_i,
  input  logic                 tail_mem_i,
  input  logic [IDX_W-1:0]     head_idx_i,
  input  logic [IDX_W-1:0]     tail_idx_i,
  input  logic [N_ENTRIES-1:0] mem_vec_i,
  output logic                 src_ok_o,
  output logic                 order_ok_o
);
  localparam int unsigned NOPS = 4;

  logic [NOPS-1:0][REG_W-1:0] op_reg;
  logic [NOPS-1:0]            op_v;
  logic [2:0]                 n_uniq;
  logic                       mem_between;

  // the tail operand fed by the head is internal to the pair
  always_comb begin
    op_reg[0] = head_src0_i;
    op_v[0]   = head_src0_v_i;
    op_reg[1] = head_src1_i;
    op_v[1]   = head_src1_v_i;
    op_reg[2] = tail_src0_i;
    op_v[2]   = tail_src0_v_i && (tail_src0_i != head_dst_i);
    op_reg[3] = tail_src1_i;
    op_v[3]   = tail_src1_v_i && (tail_src1_i != head_dst_i);
  end

  always_comb begin
    n_uniq = '0;
    for (int i = 0; i < int'(NOPS); i++) begin
      logic dup;
      dup = 1'b0;
      for (int k = 0; k < i; k++) begin
        if (op_v[k] && (op_reg[k] == op_reg[i])) dup = 1'b1;
      end
      if (op_v[i] && !dup) n_uniq = n_uniq + 3'd1;
    end
  end

  always_comb begin
    mem_between = 1'b0;
    for (int j = 0; j < int'(N_ENTRIES); j++) begin
      if (mem_vec_i[j] && (IDX_W'(j) > head_idx_i) && (IDX_W'(j) < tail_idx_i))
        mem_between = 1'b1;
    end
  end

  assign src_ok_o   = (n_uniq <= 3'(MAX_SRCS));
  assign order_ok_o = !((head_mem_i || tail_mem_i) && mem_between);
endmodule

// File: rtl/fuse_pair_scan.sv
module fuse_pair_scan
  import fuse_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 32,
  localparam int unsigned IDX_W = $clog2(N_ENTRIES),
  localparam int unsigned CNT_W = $clog2(N_ENTRIES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [REG_W-1:0] wr_dst_i,
  input  logic             wr_dst_v_i,
  input  logic [REG_W-1:0] wr_src0_i,
  input  logic             wr_src0_v_i,
  input  logic [REG_W-1:0] wr_src1_i,
  input  logic             wr_src1_v_i,
  input  logic             wr_single_i,
  input  logic             wr_mem_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             busy_o,
  output logic             done_o,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_fused_o,
  output logic             rd_tail_o,
  output logic [IDX_W-1:0] rd_head_o
);
  scan_st_e                        state_q;
  uop_t     [N_ENTRIES-1:0]        uops_q;
  logic     [N_ENTRIES-1:0]        fused_q;
  logic     [N_ENTRIES-1:0]        tail_q;
  logic     [N_ENTRIES-1:0][IDX_W-1:0] head_q;
  logic                            pass2_q;
  logic     [IDX_W-1:0]            t_q;
  logic     [CNT_W-1:0]            len_q;

  logic [N_ENTRIES-1:0]            dst_v_vec;
  logic [N_ENTRIES-1:0][REG_W-1:0] dst_vec;
  logic [N_ENTRIES-1:0]            mem_vec;
  logic [1:0][REG_W-1:0]           tsrc;
  logic [1:0]                      tsrc_v;
  logic [1:0]                      w_found;
  logic [1:0][IDX_W-1:0]           w_idx;
  logic                            cand_found;
  logic [IDX_W-1:0]                cand_idx;
  uop_t                            tail_u;
  uop_t                            head_u;
  logic                            tail_elig;
  logic                            src_ok;
  logic                            order_ok;
  logic                            pair_ok;
  logic                            last_t;

  for (genvar g = 0; g < int'(N_ENTRIES); g++) begin : g_flat
    assign dst_v_vec[g] = uops_q[g].dst_v;
    assign dst_vec[g]   = uops_q[g].dst;
    assign mem_vec[g]   = uops_q[g].mem;
  end

  assign tail_u    = uops_q[t_q];
  assign tsrc[0]   = tail_u.src0;
  assign tsrc_v[0] = tail_u.src0_v;
  assign tsrc[1]   = tail_u.src1;
  assign tsrc_v[1] = tail_u.src1_v;

  for (genvar s = 0; s < 2; s++) begin : g_src
    fuse_writer_find #(.N_ENTRIES(N_ENTRIES)) u_find (
      .dst_v_i (dst_v_vec),
      .dst_i   (dst_vec),
      .src_i   (tsrc[s]),
      .src_v_i (tsrc_v[s]),
      .limit_i (t_q),
      .found_o (w_found[s]),
      .idx_o   (w_idx[s])
    );
  end

  always_comb begin
    cand_found = |w_found;
    if (&w_found)        cand_idx = (w_idx[0] > w_idx[1]) ? w_idx[0] : w_idx[1];
    else if (w_found[0]) cand_idx = w_idx[0];
    else                 cand_idx = w_idx[1];
  end

  assign head_u = uops_q[cand_idx];

  fuse_pair_check #(.N_ENTRIES(N_ENTRIES)) u_check (
    .head_dst_i    (head_u.dst),
    .head_src0_i   (head_u.src0),
    .head_src0_v_i (head_u.src0_v),
    .head_src1_i   (head_u.src1),
    .head_src1_v_i (head_u.src1_v),
    .head_mem_i    (head_u.mem),
    .tail_src0_i   (tail_u.src0),
    .tail_src0_v_i (tail_u.src0_v),
    .tail_src1_i   (tail_u.src1),
    .tail_src1_v_i (tail_u.src1_v),
    .tail_mem_i    (tail_u.mem),
    .head_idx_i    (cand_idx),
    .tail_idx_i    (t_q),
    .mem_vec_i     (mem_vec),
    .src_ok_o      (src_ok),
    .order_ok_o    (order_ok)
  );

  assign tail_elig = !fused_q[t_q] && (pass2_q || tail_u.single);
  assign pair_ok   = (state_q == S_SCAN) && tail_elig && cand_found &&
                     !fused_q[cand_idx] && head_u.single && src_ok && order_ok;
  assign last_t    = ((CNT_W'(t_q) + CNT_W'(1)) == len_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      uops_q  <= '0;
      fused_q <= '0;
      tail_q  <= '0;
      head_q  <= '0;
      pass2_q <= 1'b0;
      t_q     <= '0;
      len_q   <= '0;
    end else begin
      if (wr_en_i && (state_q != S_SCAN)) begin
        uops_q[wr_idx_i] <= '{dst: wr_dst_i, dst_v: wr_dst_v_i,
                              src0: wr_src0_i, src0_v: wr_src0_v_i,
                              src1: wr_src1_i, src1_v: wr_src1_v_i,
                              single: wr_single_i, mem: wr_mem_i};
      end
      if (state_q == S_SCAN) begin
        if (pair_ok) begin
          fused_q[t_q]      <= 1'b1;
          fused_q[cand_idx] <= 1'b1;
          tail_q[t_q]       <= 1'b1;
          head_q[t_q]       <= cand_idx;
        end
        if (last_t) begin
          t_q <= IDX_W'(1);
          if (pass2_q) state_q <= S_DONE;
          else         pass2_q <= 1'b1;
        end else begin
          t_q <= t_q + IDX_W'(1);
        end
      end else if (start_i) begin
        fused_q <= '0;
        tail_q  <= '0;
        head_q  <= '0;
        pass2_q <= 1'b0;
        t_q     <= IDX_W'(1);
        len_q   <= len_i;
        state_q <= (len_i < CNT_W'(2)) ? S_DONE : S_SCAN;
      end
    end
  end

  assign busy_o     = (state_q == S_SCAN);
  assign done_o     = (state_q == S_DONE);
  assign rd_fused_o = fused_q[rd_idx_i];
  assign rd_tail_o  = tail_q[rd_idx_i];
  assign rd_head_o  = head_q[rd_idx_i];

  AST_TABLE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_SCAN) |=> $stable(uops_q)); // R1
  AST_PASS1_MULTI_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_SCAN && !pass2_q && !tail_u.single) |=> $stable(tail_q)); // R3
  AST_HEAD_BELOW_TAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_ok |-> (cand_idx < t_q)); // R5
  AST_FUSED_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_SCAN) |=> ((fused_q & $past(fused_q)) == $past(fused_q))); // R6
  AST_FUSED_TAIL_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_SCAN && fused_q[t_q]) |=> $stable(head_q)); // R6
endmodule

// File: tb/fuse_pair_scan_tb.sv
`timescale 1ns/100ps
module fuse_pair_scan_tb;
  localparam int N = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [4:0] wr_idx_i = '0;
  logic [4:0] wr_dst_i = '0;
  logic       wr_dst_v_i = 1'b0;
  logic [4:0] wr_src0_i = '0;
  logic       wr_src0_v_i = 1'b0;
  logic [4:0] wr_src1_i = '0;
  logic       wr_src1_v_i = 1'b0;
  logic       wr_single_i = 1'b0;
  logic       wr_mem_i = 1'b0;
  logic       start_i = 1'b0;
  logic [5:0] len_i = '0;
  logic       busy_o, done_o;
  logic [4:0] rd_idx_i = '0;
  logic       rd_fused_o, rd_tail_o;
  logic [4:0] rd_head_o;

  fuse_pair_scan u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i, .wr_idx_i, .wr_dst_i, .wr_dst_v_i, .wr_src0_i, .wr_src0_v_i,
    .wr_src1_i, .wr_src1_v_i, .wr_single_i, .wr_mem_i,
    .start_i, .len_i, .busy_o, .done_o,
    .rd_idx_i, .rd_fused_o, .rd_tail_o, .rd_head_o
  );

  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  int b_d[N], b_dv[N], b_a[N], b_av[N], b_b[N], b_bv[N], b_sc[N], b_m[N];
  int e_f[N], e_t[N], e_h[N];

  typedef struct {
    int    idx;
    int    f;
    int    t;
    int    h;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares half a cycle after the driver sets rd_idx_i
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_chk++;
      if (int'(rd_fused_o) != e.f || int'(rd_tail_o) != e.t || int'(rd_head_o) != e.h) begin
        n_bad++;
        $display("FAIL %s entry %0d: actual f=%0d t=%0d h=%0d expected f=%0d t=%0d h=%0d",
                 e.tag, e.idx, rd_fused_o, rd_tail_o, rd_head_o, e.f, e.t, e.h);
      end
    end
  end

  task automatic put(input int i, input int d, input int dv, input int a, input int av,
                     input int b, input int bv, input int sc, input int m);
    wr_en_i = 1'b1; wr_idx_i = 5'(i);
    wr_dst_i = 5'(d); wr_dst_v_i = 1'(dv);
    wr_src0_i = 5'(a); wr_src0_v_i = 1'(av);
    wr_src1_i = 5'(b); wr_src1_v_i = 1'(bv);
    wr_single_i = 1'(sc); wr_mem_i = 1'(m);
    @(posedge clk); #1;
    wr_en_i = 1'b0;
    b_d[i] = d; b_dv[i] = dv; b_a[i] = a; b_av[i] = av;
    b_b[i] = b; b_bv[i] = bv; b_sc[i] = sc; b_m[i] = m;
  endtask

  function automatic void model(input int len);
    for (int i = 0; i < N; i++) begin e_f[i] = 0; e_t[i] = 0; e_h[i] = 0; end
    for (int p = 0; p < 2; p++) begin
      for (int t = 1; t < len; t++) begin
        int j0, j1, c, n;
        int r[4];
        int v[4];
        int ok;
        if (e_f[t] != 0) continue;
        if (p == 0 && b_sc[t] == 0) continue;
        j0 = -1; j1 = -1;
        for (int j = 0; j < t; j++) begin
          if (b_dv[j] != 0 && b_av[t] != 0 && b_d[j] == b_a[t]) j0 = j;
          if (b_dv[j] != 0 && b_bv[t] != 0 && b_d[j] == b_b[t]) j1 = j;
        end
        c = (j0 > j1) ? j0 : j1;
        if (c < 0) continue;
        if (e_f[c] != 0 || b_sc[c] == 0) continue;
        r[0] = b_a[c]; v[0] = b_av[c];
        r[1] = b_b[c]; v[1] = b_bv[c];
        r[2] = b_a[t]; v[2] = (b_av[t] != 0 && b_a[t] != b_d[c]) ? 1 : 0;
        r[3] = b_b[t]; v[3] = (b_bv[t] != 0 && b_b[t] != b_d[c]) ? 1 : 0;
        n = 0;
        for (int i = 0; i < 4; i++) begin
          int dup;
          dup = 0;
          for (int k = 0; k < i; k++) if (v[k] != 0 && r[k] == r[i]) dup = 1;
          if (v[i] != 0 && dup == 0) n++;
        end
        if (n > 2) continue;
        ok = 1;
        if (b_m[c] != 0 || b_m[t] != 0)
          for (int k = c + 1; k < t; k++) if (b_m[k] != 0) ok = 0;
        if (ok == 0) continue;
        e_f[c] = 1; e_f[t] = 1; e_t[t] = 1; e_h[t] = c;
      end
    end
  endfunction

  // scoreboard driver
  task automatic readback(input string tag);
    for (int i = 0; i < N; i++) begin
      exp_t e;
      rd_idx_i = 5'(i);
      e.idx = i; e.f = e_f[i]; e.t = e_t[i]; e.h = e_h[i]; e.tag = tag;
      sb_q.push_back(e);
      @(posedge clk); #1;
    end
    while (sb_q.size() > 0) begin @(posedge clk); #1; end
  endtask

  task automatic run(input int len, input bit disturb, input string tag);
    int cyc;
    start_i = 1'b1; len_i = 6'(len);
    @(posedge clk); #1;
    start_i = 1'b0;
    chk("R2 busy after start", int'(busy_o), (len >= 2) ? 1 : 0);
    cyc = 0;
    while (!done_o && cyc < 400) begin
      if (disturb && cyc == 3) begin
        wr_en_i = 1'b1; wr_idx_i = 5'd0; wr_dst_i = 5'd31; wr_dst_v_i = 1'b1;
        wr_src0_i = 5'd30; wr_src0_v_i = 1'b1; wr_src1_v_i = 1'b0;
        wr_single_i = 1'b1; wr_mem_i = 1'b0;
        start_i = 1'b1; len_i = 6'd2;
      end
      @(posedge clk); #1;
      cyc++;
      wr_en_i = 1'b0; start_i = 1'b0;
    end
    chk({"R2 done latency ", tag}, cyc, (len < 2) ? 0 : 2 * (len - 1));
    model(len);
    readback(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      b_d[i] = 0; b_dv[i] = 0; b_a[i] = 0; b_av[i] = 0;
      b_b[i] = 0; b_bv[i] = 0; b_sc[i] = 0; b_m[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R2 reset busy", int'(busy_o), 0);
    chk("R2 reset done", int'(done_o), 0);
    model(0);
    readback("R9 reset state");

    // mixed block: pass-1 ALU pair, then pass-2 ALU-head/load-tail pair
    put(0, 1, 1, 2, 1, 0, 0, 1, 0);
    put(1, 0, 0, 1, 1, 18, 1, 0, 1);
    put(2, 3, 1, 4, 1, 5, 1, 0, 1);
    put(3, 1, 1, 1, 1, 0, 0, 1, 0);
    put(4, 21, 1, 1, 1, 6, 1, 1, 0);
    put(5, 7, 1, 21, 1, 0, 0, 0, 1);
    run(6, 1'b0, "R3 R4 R6 two-sweep block");
    chk("R4 load tail fused", e_t[5], 1);

    // same table, shorter length: entries 4 and 5 out of range
    run(4, 1'b0, "R10 length bound");

    // store between head and load tail
    put(0, 1, 1, 2, 1, 0, 0, 1, 0);
    put(1, 0, 0, 3, 1, 0, 0, 0, 1);
    put(2, 4, 1, 1, 1, 0, 0, 0, 1);
    run(3, 1'b0, "R8 memory order");

    // three distinct sources rejected, two accepted
    put(0, 1, 1, 2, 1, 3, 1, 1, 0);
    put(1, 4, 1, 1, 1, 5, 1, 1, 0);
    put(2, 6, 1, 1, 1, 0, 0, 1, 0);
    run(3, 1'b0, "R7 operand count");

    // nearest writer wins
    put(0, 1, 1, 9, 1, 0, 0, 1, 0);
    put(1, 1, 1, 9, 1, 0, 0, 1, 0);
    put(2, 2, 1, 1, 1, 0, 0, 1, 0);
    run(3, 1'b0, "R5 nearest writer");

    // fused writer blocks a later consumer
    put(0, 1, 1, 9, 1, 0, 0, 1, 0);
    put(1, 2, 1, 1, 1, 0, 0, 1, 0);
    put(2, 3, 1, 1, 1, 0, 0, 1, 0);
    run(3, 1'b0, "R6 fused head");

    // multi-cycle head rejected; pass-1 precedence over a load tail
    put(0, 1, 1, 2, 1, 0, 0, 0, 0);
    put(1, 3, 1, 1, 1, 0, 0, 1, 0);
    put(2, 4, 1, 5, 1, 0, 0, 1, 0);
    put(3, 6, 1, 7, 1, 0, 0, 0, 1);
    put(4, 8, 1, 4, 1, 0, 0, 1, 0);
    put(5, 9, 1, 4, 1, 0, 0, 0, 1);
    run(6, 1'b0, "R3 R4 head and precedence");

    run(1, 1'b0, "R10 single entry");
    run(0, 1'b0, "R10 empty block");

    // full table, disturbed in mid-scan
    for (int i = 0; i < N; i++) begin
      int m, sc;
      m  = ((i % 4) == 2 || (i % 5) == 4) ? 1 : 0;
      sc = (m == 0 && (i % 7) != 6) ? 1 : 0;
      put(i, ((i * 7 + 3) % 8) + 1, ((i % 5) == 4) ? 0 : 1,
          ((i * 3) % 8) + 1, 1, (i * 5 + 2) % 10, ((i % 3) == 0) ? 1 : 0, sc, m);
    end
    run(N, 1'b1, "R1 busy ignores writes");
    run(N, 1'b0, "R9 rerun clears");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule